// File: doc/BRIEF.md
# Floating-point control and status register

This block holds the software-visible control and status word of a single-precision floating-point unit. The word carries two fields. A 3-bit rounding-mode field selects the rounding used by instructions that ask for dynamic rounding. A 5-bit exception-flag field accumulates the exception conditions raised by arithmetic results. Software reaches the word through CSR-style requests. Each request names a target: the whole word, the rounding field alone, or the flag field alone. Each request also names an operation: read, swap, bit-set or bit-clear. Every request returns the addressed value as it stood before the request.

On every cycle the arithmetic pipeline can deliver a set of newly raised exception flags, and the block ORs them into the sticky flag field. The instruction's own rounding-mode code goes through the block, which resolves it into the effective mode and reports when that mode is a reserved encoding. The block also sits on the result path. It replaces any NaN result with the canonical single-precision quiet NaN and passes every other result through unchanged.

Top module: `fp_csr_unit`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, frm_o, fflags_o and csr_rdata_o are all zero.
- R2: The whole-word view places the rounding mode in bits 7:5 and the flags in bits 4:0. The flag bits, from bit 4 down to bit 0, are: invalid, divide-by-zero, overflow, underflow, inexact. Target codes are 0 for the whole word, 1 for the rounding field and 2 for the flag field.
- R3: A swap request (op code 1) puts the addressed value, as it stood before the request, on csr_rdata_o. The same request loads the new value at the next clock edge. The new value comes from csr_wdata_i[7:0] for the whole word, from csr_wdata_i[2:0] for the rounding field, and from csr_wdata_i[4:0] for the flag field.
- R4: A read request (op code 0) returns the addressed value and changes neither field.
- R5: A set request (op code 2) ORs the mask into the addressed field only. A clear request (op code 3) removes the mask bits from the addressed field only. Both return the prior value.
- R6: Bits 31:8 of the word ignore writes and always read as zero. Target code 3 reads as zero and changes nothing. With csr_req_i low, nothing changes.
- R7: The flags are sticky. When exc_valid_i is high, every bit of exc_flags_i is set in fflags_o after the clock edge, and it stays set until a CSR request writes it to zero.
- R8: When a CSR request writes the flag field in the same cycle that arithmetic flags arrive, the new flag value is the CSR result ORed with exc_flags_i.
- R9: The effective rounding mode eff_rm_o equals inst_rm_i unless inst_rm_i is 7, in which case it equals the stored mode. Encodings 0 to 4 are legal. rm_bad_o is high exactly when eff_rm_o is 5, 6 or 7.
- R10: When res_i is a NaN (exponent all ones, nonzero significand), res_o is 0x7fc00000. Any other value, infinities included, passes through unchanged.
- R11: With csr_req_i low, csr_rdata_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_req_i | input | 1 | CSR request valid |
| csr_tgt_i | input | 2 | Target: 0 whole word, 1 rounding field, 2 flag field, 3 none |
| csr_op_i | input | 2 | Operation: 0 read, 1 swap, 2 set, 3 clear |
| csr_wdata_i | input | 32 | Write data or bit mask from the integer source |
| csr_rdata_o | output | 32 | Prior value of the addressed target |
| exc_valid_i | input | 1 | Arithmetic flags valid this cycle |
| exc_flags_i | input | 5 | Raised exception flags, same order as the flag field |
| inst_rm_i | input | 3 | Rounding code from the instruction; 7 requests the stored mode |
| eff_rm_o | output | 3 | Resolved rounding mode |
| rm_bad_o | output | 1 | Resolved rounding mode is a reserved encoding |
| res_i | input | 32 | Raw single-precision result |
| res_o | output | 32 | Result with NaNs replaced by the canonical NaN |
| frm_o | output | 3 | Stored rounding mode |
| fflags_o | output | 5 | Accrued exception flags |

## Verification
The bench aims at field placement. A swap of the whole word carries garbage in bits 31:8. If the upper bits were not masked, they would show up in the readback. If the rounding mask were taken from the wrong bits of the write data, the field would load the wrong mode. Set and clear are driven on each target in turn, with masks that overlap the other field, so a decode that spills across fields changes the field that was not addressed. A flag swap and a raised exception land in the same cycle; a design that lets either one win over the other loses bits that should be set. The reserved and dynamic rounding codes are exercised through both the stored and the static path. Signalling and quiet NaNs of both signs go through the result path alongside infinities, because a NaN test written as "exponent all ones" would rewrite infinities.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
  parameter int unsigned XLEN   = 32;
  parameter int unsigned RM_W   = 3;
  parameter int unsigned FLG_W  = 5;
  parameter int unsigned EXP_W  = 8;
  parameter int unsigned MAN_W  = 23;

  localparam int unsigned IMPL_W = RM_W + FLG_W;
  localparam int unsigned RM_LSB = FLG_W;

  // flag bit positions inside the flag field
  localparam int unsigned FLG_NX = 0;
  localparam int unsigned FLG_UF = 1;
  localparam int unsigned FLG_OF = 2;
  localparam int unsigned FLG_DZ = 3;
  localparam int unsigned FLG_NV = 4;

  localparam logic [RM_W-1:0] RM_DYN       = 3'd7;
  localparam logic [RM_W-1:0] RM_FIRST_BAD = 3'd5;

  localparam logic [XLEN-1:0] CANON_NAN = 32'h7fc0_0000;

  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_SWAP = 2'd1,
    OP_SET  = 2'd2,
    OP_CLR  = 2'd3
  } csr_op_e;

  typedef enum logic [1:0] {
    TGT_ALL  = 2'd0,
    TGT_RM   = 2'd1,
    TGT_FLG  = 2'd2,
    TGT_NONE = 2'd3
  } csr_tgt_e;
endpackage

// File: rtl/fcsr_field_update.sv
module fcsr_field_update #(
  parameter int unsigned W = 3
) (
  input  logic             hit_i,
  input  fcsr_pkg::csr_op_e op_i,
  input  logic [W-1:0]     mask_i,
  input  logic [W-1:0]     cur_i,
  output logic [W-1:0]     nxt_o,
  output logic             mod_o
);
  import fcsr_pkg::*;

  always_comb begin
    nxt_o = cur_i;
    mod_o = 1'b0;
    if (hit_i) begin
      unique case (op_i)
        OP_SWAP: begin nxt_o = mask_i;          mod_o = 1'b1; end
        OP_SET:  begin nxt_o = cur_i | mask_i;  mod_o = 1'b1; end
        OP_CLR:  begin nxt_o = cur_i & ~mask_i; mod_o = 1'b1; end
        default: nxt_o = cur_i;
      endcase
    end
  end
endmodule

// File: rtl/fcsr_rm_resolve.sv
module fcsr_rm_resolve #(
  parameter int unsigned RM_W = fcsr_pkg::RM_W
) (
  input  logic [RM_W-1:0] inst_rm_i,
  input  logic [RM_W-1:0] frm_i,
  output logic [RM_W-1:0] eff_rm_o,
  output logic            bad_o
);
  import fcsr_pkg::*;

  always_comb begin
    eff_rm_o = (inst_rm_i == RM_DYN) ? frm_i : inst_rm_i;
    bad_o    = (eff_rm_o >= RM_FIRST_BAD);
  end

  always_comb begin
    if (inst_rm_i < RM_FIRST_BAD)
      AST_STATIC_LEGAL: assert (!bad_o && eff_rm_o == inst_rm_i); // R9
  end
endmodule

// File: rtl/fcsr_nan_canon.sv
module fcsr_nan_canon #(
  parameter int unsigned EXP_W = fcsr_pkg::EXP_W,
  parameter int unsigned MAN_W = fcsr_pkg::MAN_W,
  localparam int unsigned DW   = 1 + EXP_W + MAN_W
) (
  input  logic [DW-1:0] res_i,
  output logic [DW-1:0] res_o
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             is_nan;
  logic [DW-1:0]    canon;

  assign exp_f  = res_i[DW-2 -: EXP_W];
  assign man_f  = res_i[MAN_W-1:0];
  assign is_nan = (&exp_f) && (|man_f);
  // sign 0, exponent all ones, only the quiet bit of the significand
  assign canon  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  assign res_o  = is_nan ? canon : res_i;

  always_comb begin
    if (is_nan)
      AST_NAN_QUIET: assert (res_o[MAN_W-1] && !res_o[DW-1] && res_o[MAN_W-2:0] == '0); // R10
  end
endmodule

// File: rtl/fp_csr_unit.sv
module fp_csr_unit
  import fcsr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csr_req_i,
  input  logic [1:0]       csr_tgt_i,
  input  logic [1:0]       csr_op_i,
  input  logic [XLEN-1:0]  csr_wdata_i,
  output logic [XLEN-1:0]  csr_rdata_o,
  input  logic             exc_valid_i,
  input  logic [FLG_W-1:0] exc_flags_i,
  input  logic [RM_W-1:0]  inst_rm_i,
  output logic [RM_W-1:0]  eff_rm_o,
  output logic             rm_bad_o,
  input  logic [XLEN-1:0]  res_i,
  output logic [XLEN-1:0]  res_o,
  output logic [RM_W-1:0]  frm_o,
  output logic [FLG_W-1:0] fflags_o
);
  csr_op_e  op;
  csr_tgt_e tgt;
  logic [RM_W-1:0]  rm_q, rm_nxt, rm_mask;
  logic [FLG_W-1:0] flg_q, flg_nxt, flg_mask, exc_in;
  logic             rm_hit, flg_hit, rm_mod, flg_mod;

  assign op  = csr_op_e'(csr_op_i);
  assign tgt = csr_tgt_e'(csr_tgt_i);

  assign rm_hit   = csr_req_i && (tgt == TGT_ALL || tgt == TGT_RM);
  assign flg_hit  = csr_req_i && (tgt == TGT_ALL || tgt == TGT_FLG);
  assign rm_mask  = (tgt == TGT_ALL) ? csr_wdata_i[RM_LSB +: RM_W] : csr_wdata_i[RM_W-1:0];
  assign flg_mask = csr_wdata_i[FLG_W-1:0];

  // one update slice per field
  for (genvar g = 0; g < 2; g++) begin : g_field
    if (g == 0) begin : g_rm
      fcsr_field_update #(.W(RM_W)) i_upd (
        .hit_i (rm_hit), .op_i (op), .mask_i (rm_mask),
        .cur_i (rm_q), .nxt_o (rm_nxt), .mod_o (rm_mod)
      );
    end else begin : g_flg
      fcsr_field_update #(.W(FLG_W)) i_upd (
        .hit_i (flg_hit), .op_i (op), .mask_i (flg_mask),
        .cur_i (flg_q), .nxt_o (flg_nxt), .mod_o (flg_mod)
      );
    end
  end

  assign exc_in = exc_valid_i ? exc_flags_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rm_q  <= '0;
      flg_q <= '0;
    end else begin
      rm_q  <= rm_nxt;
      flg_q <= flg_nxt | exc_in;
    end
  end

  always_comb begin
    csr_rdata_o = '0;
    if (csr_req_i) begin
      unique case (tgt)
        TGT_ALL:  csr_rdata_o[IMPL_W-1:0] = {rm_q, flg_q};
        TGT_RM:   csr_rdata_o[RM_W-1:0]   = rm_q;
        TGT_FLG:  csr_rdata_o[FLG_W-1:0]  = flg_q;
        default:  csr_rdata_o = '0;
      endcase
    end
  end

  assign frm_o    = rm_q;
  assign fflags_o = flg_q;

  fcsr_rm_resolve #(.RM_W(RM_W)) i_rm_resolve (
    .inst_rm_i (inst_rm_i), .frm_i (rm_q),
    .eff_rm_o  (eff_rm_o),  .bad_o (rm_bad_o)
  );

  fcsr_nan_canon #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_nan_canon (
    .res_i (res_i), .res_o (res_o)
  );

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_req_i && |csr_wdata_i[XLEN-1:IMPL_W]) |=> csr_rdata_o[XLEN-1:IMPL_W] == '0); // R6
  AST_RM_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rm_mod |=> $stable(frm_o)); // R4
  AST_FLG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flg_mod |=> (fflags_o & $past(fflags_o)) == $past(fflags_o)); // R7
  AST_EXC_MERGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |=> (fflags_o & $past(exc_flags_i)) == $past(exc_flags_i)); // R8
  AST_IDLE_RDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_req_i |-> csr_rdata_o == '0); // R11
endmodule

// File: tb/test_fp_csr_unit.sv
`timescale 1ns/1ps
module test_fp_csr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  tgt = 2'd0, op = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        exc_v = 1'b0;
  logic [4:0]  exc = '0;
  logic [2:0]  inst_rm = 3'd0;
  logic [2:0]  eff_rm;
  logic        rm_bad;
  logic [31:0] res_in = '0, res_out;
  logic [2:0]  frm;
  logic [4:0]  fflags;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fp_csr_unit i_fp_csr_unit (
    .clk_i (clk), .rst_ni (rst_n), .csr_req_i (req), .csr_tgt_i (tgt),
    .csr_op_i (op), .csr_wdata_i (wdata), .csr_rdata_o (rdata),
    .exc_valid_i (exc_v), .exc_flags_i (exc), .inst_rm_i (inst_rm),
    .eff_rm_o (eff_rm), .rm_bad_o (rm_bad), .res_i (res_in), .res_o (res_out),
    .frm_o (frm), .fflags_o (fflags)
  );

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  tgt;
    logic [1:0]  op;
    logic [31:0] wdata;
    logic        exc_v;
    logic [4:0]  exc;
    logic [31:0] exp_rdata;
    logic [7:0]  exp_word;
  } vec_t;

  // sequential vectors; exp_word = {frm, fflags} after the edge
  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'd1, 32'hFFFF_FFAB, 1'b0, 5'h00, 32'h0000_0000, 8'hAB}, // R3 R6 whole swap
    '{2'd0, 2'd0, 32'h0000_0055, 1'b0, 5'h00, 32'h0000_00AB, 8'hAB}, // R4 R2 read
    '{2'd1, 2'd1, 32'hFFFF_FFF2, 1'b0, 5'h00, 32'h0000_0005, 8'h4B}, // R3 rm swap
    '{2'd2, 2'd1, 32'h0000_0010, 1'b1, 5'h01, 32'h0000_000B, 8'h51}, // R8 swap + exc
    '{2'd2, 2'd2, 32'h0000_00E6, 1'b0, 5'h00, 32'h0000_0011, 8'h57}, // R5 flag set
    '{2'd2, 2'd3, 32'h0000_00F3, 1'b0, 5'h00, 32'h0000_0017, 8'h44}, // R5 flag clear
    '{2'd1, 2'd2, 32'h0000_00FD, 1'b0, 5'h00, 32'h0000_0002, 8'hE4}, // R5 rm set
    '{2'd1, 2'd3, 32'h0000_001B, 1'b0, 5'h00, 32'h0000_0007, 8'h84}, // R5 rm clear
    '{2'd0, 2'd2, 32'hFFFF_FF03, 1'b0, 5'h00, 32'h0000_0084, 8'h87}, // R5 R6 whole set
    '{2'd0, 2'd3, 32'h0000_0081, 1'b0, 5'h00, 32'h0000_0087, 8'h06}, // R5 whole clear
    '{2'd3, 2'd1, 32'hFFFF_FFFF, 1'b1, 5'h08, 32'h0000_0000, 8'h0E}, // R6 target none
    '{2'd2, 2'd0, 32'h0000_0000, 1'b1, 5'h10, 32'h0000_000E, 8'h1E}, // R7 read + exc
    '{2'd0, 2'd1, 32'h0000_0000, 1'b1, 5'h01, 32'h0000_001E, 8'h01}  // R8 whole swap + exc
  };

  initial begin : watchdog
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (2) @(negedge clk);
    chk("R1 frm in reset", {29'b0, frm}, 32'h0);
    chk("R1 flags in reset", {27'b0, fflags}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 word after reset", {24'b0, frm, fflags}, 32'h0);
    chk("R11 idle rdata", rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req = 1'b1; tgt = VEC[i].tgt; op = VEC[i].op; wdata = VEC[i].wdata;
      exc_v = VEC[i].exc_v; exc = VEC[i].exc;
      #1 chk($sformatf("R3/R4/R6 rdata vec %0d", i), rdata, VEC[i].exp_rdata);
      @(posedge clk); #1;
      req = 1'b0; exc_v = 1'b0;
      chk($sformatf("R2/R5/R8 word vec %0d", i), {24'b0, frm, fflags}, {24'b0, VEC[i].exp_word});
    end

    // R6 / R11: request low with write data present changes nothing
    @(negedge clk);
    req = 1'b0; tgt = 2'd0; op = 2'd1; wdata = 32'h0000_00FF;
    #1 chk("R11 rdata without request", rdata, 32'h0);
    @(posedge clk); #1;
    chk("R6 no request no change", {24'b0, frm, fflags}, 32'h01);

    // R7: sticky across idle cycles
    @(negedge clk); exc_v = 1'b1; exc = 5'h04;
    @(posedge clk); #1 exc_v = 1'b0; exc = 5'h00;
    repeat (3) @(negedge clk);
    chk("R7 flags stay set", {27'b0, fflags}, 32'h05);

    // R9: rounding resolution
    @(negedge clk); req = 1'b1; tgt = 2'd1; op = 2'd1; wdata = 32'h3;
    @(posedge clk); #1 req = 1'b0;
    inst_rm = 3'd7; #1;
    chk("R9 dyn uses stored", {29'b0, eff_rm}, 32'h3);
    chk("R9 stored legal", {31'b0, rm_bad}, 32'h0);
    inst_rm = 3'd5; #1 chk("R9 static reserved", {31'b0, rm_bad}, 32'h1);
    inst_rm = 3'd2; #1 chk("R9 static passes", {29'b0, eff_rm}, 32'h2);
    @(negedge clk); req = 1'b1; tgt = 2'd1; op = 2'd1; wdata = 32'h6;
    @(posedge clk); #1 req = 1'b0;
    inst_rm = 3'd7; #1 chk("R9 stored reserved", {31'b0, rm_bad}, 32'h1);
    @(negedge clk); req = 1'b1; tgt = 2'd1; op = 2'd1; wdata = 32'h7;
    @(posedge clk); #1 req = 1'b0;
    #1 chk("R9 stored dyn code", {31'b0, rm_bad}, 32'h1);
    inst_rm = 3'd4; #1 chk("R9 static legal", {31'b0, rm_bad}, 32'h0);

    // R10: NaN canonicalisation
    res_in = 32'h7f80_0001; #1 chk("R10 snan", res_out, 32'h7fc0_0000);
    res_in = 32'hffc1_2345; #1 chk("R10 negative qnan", res_out, 32'h7fc0_0000);
    res_in = 32'h7f80_0000; #1 chk("R10 +inf passes", res_out, 32'h7f80_0000);
    res_in = 32'hff80_0000; #1 chk("R10 -inf passes", res_out, 32'hff80_0000);
    res_in = 32'h3f80_0000; #1 chk("R10 normal passes", res_out, 32'h3f80_0000);

    // R1: asynchronous reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1 async reset", {24'b0, frm, fflags}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule